// File: doc/BRIEF.md
# Receive Link Fault Aggregator with Channel Enable Hold

This block turns the digital signal-quality indications of four receive lanes into one registered status line per lane. The status line is high when the lane carries a usable signal and low when it has a fault. Each lane supplies three monitor bits: amplitude above threshold, enough transitions, and frequency within range. A global loopback select removes the amplitude term, because no line receiver is in use during loopback.

A shared 8-bit enable bus feeds a level-sensitive hold stage. While the strobe is high, the bus passes straight through. When the strobe falls, the bus value is frozen until the strobe rises again. Lane k is switched on by bit 2k of the held value. A disabled lane always reports fault.

Every monitor, the loopback select and the held enable bit are brought into each lane's own receive clock through a two-flop synchronizer. After a lane is switched back on, its status is forced to fault for a programmable number of clocks. This covers the time the lane needs to settle.

Top module: `link_fault_agg`

## Requirements
- R1: With loopback off and the lane enabled and past its settling mask, the status line is high exactly when the amplitude, transition and frequency monitors are all high.
- R2: The status line is active high for a valid signal and low for a fault. It is low in the first clock after a synchronous reset.
- R3: While `en_le` is high, `en_held` equals `en_bus`. While `en_le` is low, `en_held` keeps the value it had when `en_le` fell, whatever `en_bus` does.
- R4: A lane whose enable bit is low reports a constant low status for any monitor values.
- R5: With loopback on, the amplitude monitor is ignored. The status is then the AND of the transition monitor, the frequency monitor and the enable.
- R6: After a lane's enable bit goes high, its status stays low for SETTLE_CYC+2 rising edges of its clock. The earliest edge at which it can go high is the (SETTLE_CYC+3)th.
- R7: Bit 2k of `en_held` enables lane k. Bit 2k+1 has no effect on any lane.
- R8: A change on a monitor input or on loopback reaches the status line at the third rising edge of the lane clock, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | NUM_CH | Receive clock of each lane |
| rst | input | 1 | Synchronous active-high reset, sampled in each lane clock |
| en_bus | input | 2*NUM_CH | Lane enable bus; bit 2k controls lane k |
| en_le | input | 1 | Hold strobe: high passes the bus through, low holds it |
| loopback | input | 1 | Loopback select; drops the amplitude term |
| amp_ok | input | NUM_CH | Amplitude above threshold, per lane |
| trans_ok | input | NUM_CH | Transition density sufficient, per lane |
| freq_ok | input | NUM_CH | Signalling rate in range, per lane |
| en_held | output | 2*NUM_CH | Current value of the enable hold stage |
| link_good | output | NUM_CH | Registered status, high = valid, low = fault |

## Verification
A stuck or wrongly loaded settling counter shows up as a status line that rises too early or too late after an enable. The bench times this edge by edge. A synchronizer with the wrong depth shifts every monitor response by a cycle, which the latency checks catch at the second and third edges. A wrong enable bit or a misplaced loopback mask shows within three edges in the sweep of all monitor combinations.

// File: rtl/lfa_pkg.sv
package lfa_pkg;
  typedef struct packed {
    logic amp;
    logic trans;
    logic freq;
    logic lb;
    logic en;
  } mon_t;
  localparam int MON_W = $bits(mon_t);
endpackage

// File: rtl/lfa_sync.sv
module lfa_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lfa_en_latch.sv
module lfa_en_latch #(
  parameter int W = 8
) (
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (le) q = d;
  end
endmodule

// File: rtl/lfa_chan.sv
module lfa_chan
  import lfa_pkg::*;
#(
  parameter int SETTLE_CYC  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  mon_t mon_a,
  output logic good
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYC);

  mon_t          mon_s;
  logic [CW-1:0] cnt;
  logic          good_q;

  lfa_sync #(.W(MON_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (mon_a),
    .q   (mon_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= CNT_LOAD;
      good_q <= 1'b0;
    end else begin
      if (!mon_s.en)      cnt <= CNT_LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
      good_q <= mon_s.en && (cnt == '0) && mon_s.trans && mon_s.freq
                && (mon_s.lb || mon_s.amp);
    end
  end

  assign good = good_q;

  // R4
  dis_fault_chk: assert property (@(posedge clk) disable iff (rst)
    !mon_s.en |=> !good_q);
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> !good_q);
  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LOAD);
  // R1
  freq_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (!mon_s.freq || !mon_s.trans) |=> !good_q);
  // R5
  amp_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (!mon_s.lb && !mon_s.amp) |=> !good_q);
endmodule

// File: rtl/link_fault_agg.sv
module link_fault_agg
  import lfa_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SETTLE_CYC  = 64,
  parameter int SYNC_STAGES = 2,
  localparam int EN_W       = 2 * NUM_CH
) (
  input  logic [NUM_CH-1:0] rx_clk,
  input  logic              rst,
  input  logic [EN_W-1:0]   en_bus,
  input  logic              en_le,
  input  logic              loopback,
  input  logic [NUM_CH-1:0] amp_ok,
  input  logic [NUM_CH-1:0] trans_ok,
  input  logic [NUM_CH-1:0] freq_ok,
  output logic [EN_W-1:0]   en_held,
  output logic [NUM_CH-1:0] link_good
);
  lfa_en_latch #(.W(EN_W)) u_latch (
    .le (en_le),
    .d  (en_bus),
    .q  (en_held)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    mon_t mon;
    assign mon.amp   = amp_ok[k];
    assign mon.trans = trans_ok[k];
    assign mon.freq  = freq_ok[k];
    assign mon.lb    = loopback;
    assign mon.en    = en_held[2*k];

    lfa_chan #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk   (rx_clk[k]),
      .rst   (rst),
      .mon_a (mon),
      .good  (link_good[k])
    );

    // R2
    rst_fault_chk: assert property (@(posedge rx_clk[k])
      rst |=> !link_good[k]);
  end
endmodule

// File: tb/sim_link_fault_agg.sv
module sim_link_fault_agg;
  localparam int CLK_P  = 10;
  localparam int NCH    = 4;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic           rst;
  logic [7:0]     en_bus;
  logic           en_le, loopback;
  logic [NCH-1:0] amp_ok, trans_ok, freq_ok;
  logic [7:0]     en_held;
  logic [NCH-1:0] link_good;

  int checks = 0;
  int failures = 0;

  link_fault_agg #(.NUM_CH(NCH), .SETTLE_CYC(SETTLE)) u0 (
    .rx_clk({NCH{clk}}), .rst(rst), .en_bus(en_bus), .en_le(en_le),
    .loopback(loopback), .amp_ok(amp_ok), .trans_ok(trans_ok),
    .freq_ok(freq_ok), .en_held(en_held), .link_good(link_good)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NCH-1:0] expect_good(input logic [7:0] en,
      input logic lb, input logic [NCH-1:0] a, t, f);
    logic [NCH-1:0] r;
    for (int k = 0; k < NCH; k++)
      r[k] = en[2*k] & t[k] & f[k] & (lb | a[k]);
    return r;
  endfunction

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; en_le = 1'b1; en_bus = 8'h00; loopback = 1'b0;
    amp_ok = '1; trans_ok = '1; freq_ok = '1;
    step(3);
    // R2: reset state
    chk("R2 reset", 8'(link_good), 8'h0);
    rst = 1'b0;

    // R6: settling mask after enable
    en_bus = 8'h55;
    step(SETTLE + 2);
    chk("R6 masked", 8'(link_good), 8'h0);
    step(1);
    chk("R6 released", 8'(link_good), 8'hF);

    // R8: latency of a monitor change
    freq_ok = '0;
    step(2);
    chk("R8 before third edge", 8'(link_good), 8'hF);
    step(1);
    chk("R8 at third edge", 8'(link_good), 8'h0);

    // R1 / R5: sweep of monitor patterns with and without loopback
    for (int lb = 0; lb < 2; lb++) begin
      for (int p = 0; p < 8; p++) begin
        loopback = lb[0];
        for (int k = 0; k < NCH; k++) begin
          amp_ok[k]   = 1'((p + k) >> 0);
          trans_ok[k] = 1'((p + k) >> 1);
          freq_ok[k]  = 1'((p + k) >> 2);
        end
        step(3);
        chk(lb ? "R5 loopback sweep" : "R1 sweep", 8'(link_good),
            8'(expect_good(en_held, loopback, amp_ok, trans_ok, freq_ok)));
      end
    end

    // R3: hold stage freezes when strobe is low
    loopback = 1'b0; amp_ok = '1; trans_ok = '1; freq_ok = '1;
    en_le = 1'b0;
    en_bus = 8'h00;
    #1;
    chk("R3 held value", en_held, 8'h55);
    step(3);
    chk("R3 lanes stay enabled", 8'(link_good), 8'hF);
    en_le = 1'b1;
    #1;
    chk("R3 transparent", en_held, 8'h00);

    // R4: disabled lanes report fault for any monitor pattern
    step(3);
    chk("R4 all disabled", 8'(link_good), 8'h0);
    loopback = 1'b1;
    step(3);
    chk("R4 disabled loopback", 8'(link_good), 8'h0);
    loopback = 1'b0;

    // R7: odd bits enable nothing
    en_bus = 8'hAA;
    step(SETTLE + 3);
    chk("R7 odd bits held", en_held, 8'hAA);
    chk("R7 odd bits no effect", 8'(link_good), 8'h0);

    // R7 / R4: single lanes enabled via bit 2k
    for (int k = 0; k < NCH; k++) begin
      en_bus = 8'(1 << (2*k)) | 8'hAA;
      step(SETTLE + 3);
      chk("R7 single lane", 8'(link_good), 8'(1 << k));
    end

    // R4: disable one lane among enabled ones
    en_bus = 8'h55;
    step(SETTLE + 3);
    en_bus = 8'h45;
    step(3);
    chk("R4 lane 2 disabled", 8'(link_good), 8'hB);

    // R2: reset again clears status
    rst = 1'b1;
    step(1);
    chk("R2 reset mid-run", 8'(link_good), 8'h0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule